// File: doc/BRIEF.md
# I2C Register Access Master

This block is a bus master for a two-wire serial bus. Each command reads or writes one 8-bit register inside an external slave device. The host supplies four things: an address byte (7-bit device address plus the direction bit in bit 0), a register index, a write value and a read/write selector. It then pulses `go`. The block runs the whole frame on its own and pulses `done` when the frame is finished. At that moment `err` reports whether any acknowledge was missing, and `rd_data` holds the byte that was read.

Both bus lines behave as open-drain outputs. The block never drives a line high. A pull-low enable (`scl_oe`, `sda_oe`) grounds the line, and releasing that enable lets the external pull-up raise it.

Every bus bit occupies one slot of four equal quarters:
- SCL is pulled low in the first quarter and released in the third.
- SDA may move only at the start of the second and fourth quarters.

The slave's acknowledge is polled. SDA is sampled late in the third quarter. If SDA is still high, a further clock pulse is issued, up to a retry limit.

After reset the block first issues a run of stop sequences to free a slave that may be holding SDA low. It accepts commands only after that run has finished.

Top module: `i2c_regxfer`

## Requirements
- R1: After reset, `busy` is high while exactly INIT_STOPS stop sequences are issued with no start condition. `busy` then falls. `done` does not pulse during this run, and a `go` seen during it is ignored.
- R2: Each bus slot lasts four quarters of QCYC clocks each. SCL is pulled low for exactly 2*QCYC cycles per slot and released for the other two quarters. SDA never changes in the same cycle as SCL.
- R3: A line is only ever pulled low or released. While `busy` is low, both `scl_oe` and `sda_oe` are 0 (released).
- R4: A start releases SDA in quarter 2 and pulls it low in quarter 4 while SCL is released. A stop pulls SDA low in quarter 2 and releases it in quarter 4 while SCL is released. SDA never changes while SCL is high except in these two conditions.
- R5: Bytes are sent most significant bit first, eight data slots per byte, with SDA pulled low for a 0 bit and released for a 1 bit. A ninth slot with SDA released follows for the acknowledge.
- R6: The acknowledge is taken from SDA after a two-flop synchroniser, late in quarter 3. While SDA reads high, another clock pulse is given, up to ACK_TRIES samples in total. A low sample accepts the byte.
- R7: With `cmd_read`=0, the frame is: start, the address byte exactly as given, the register index, the write value, stop. This gives 29 SCL pulses plus one for every extra acknowledge pulse.
- R8: With `cmd_read`=1, the frame is: start, address byte, register index, a repeated start, the address byte with bit 0 forced to 1, eight read slots with SDA released (the bit is sampled in quarter 3, MSB first), no acknowledge, then stop. `rd_data` then holds the byte.
- R9: If an acknowledge is missing after ACK_TRIES samples, the remaining bytes are skipped, a stop is issued, `err` is 1 at `done`, and `rd_data` is left unchanged. `err` clears only when a new command is accepted.
- R10: `busy` rises only in the cycle after an accepted `go` and stays high until the final stop ends. A `go` while busy is ignored. `done` is a one-cycle pulse with `busy` already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Command strobe, taken when not busy |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| dev_addr | input | 8 | Device address byte, direction bit in bit 0 |
| reg_idx | input | 8 | Register index inside the slave |
| wr_data | input | 8 | Value for a register write |
| sda_in | input | 1 | Level seen on the SDA wire |
| busy | output | 1 | Initial clearing or a frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a command frame |
| err | output | 1 | Some acknowledge missing in the last frame |
| rd_data | output | 8 | Byte read by the last successful read |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with a quarter of 4 clocks, ACK_TRIES of 4 and INIT_STOPS of 3. With these values a full write frame takes about 500 cycles, so every acknowledge delay that still succeeds (0 to 3 extra pulses) can be swept against many byte values, and every rejection point can be exercised as well. The slave model on the wired-AND bus counts starts, stops and SCL pulses and logs each received byte. This checks the exact frame shape, the retry count and the pulse widths against counts the bench derives from the bytes and the delays.

// File: rtl/i2c_regxfer_pkg.sv
package i2c_regxfer_pkg;
  // Kind of the bus slot currently being generated
  typedef enum logic [2:0] {
    SL_IDLE,
    SL_START,
    SL_TX,
    SL_ACK,
    SL_RX,
    SL_STOP
  } slot_e;
endpackage

// File: rtl/i2c_qphase.sv
// Quarter-phase timer: counts QCYC clocks per quarter, four quarters per slot
module i2c_qphase #(
  parameter int QCYC = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic [1:0] q,
  output logic       q_last
);
  localparam int CW = (QCYC < 2) ? 1 : $clog2(QCYC);

  logic [CW-1:0] cnt;

  assign q_last = run && (cnt == CW'(QCYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (q_last) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/i2c_sync2.sv
// Two-flop synchroniser for the incoming data line
module i2c_sync2 #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/i2c_linectl.sv
// Registered pull-low enables for both lines, set per slot kind and quarter
module i2c_linectl
  import i2c_regxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slot_e      kind,
  input  logic [1:0] q,
  input  logic       tx_bit,
  output logic       scl_oe,
  output logic       sda_oe
);
  always_ff @(posedge clk) begin
    if (rst || kind == SL_IDLE) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (q)
        2'd0: scl_oe <= 1'b1;
        2'd1: begin
          case (kind)
            SL_STOP: sda_oe <= 1'b1;
            SL_TX:   sda_oe <= ~tx_bit;
            default: sda_oe <= 1'b0;
          endcase
        end
        2'd2: scl_oe <= 1'b0;
        default: begin
          if (kind == SL_START) sda_oe <= 1'b1;
          else if (kind == SL_STOP) sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_regxfer.sv
module i2c_regxfer
  import i2c_regxfer_pkg::*;
#(
  parameter int QCYC       = 250,
  parameter int ACK_TRIES  = 255,
  parameter int INIT_STOPS = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       cmd_read,
  input  logic [7:0] dev_addr,
  input  logic [7:0] reg_idx,
  input  logic [7:0] wr_data,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic [7:0] rd_data,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int TW = (ACK_TRIES < 2) ? 1 : $clog2(ACK_TRIES);
  localparam int IW = (INIT_STOPS < 1) ? 1 : $clog2(INIT_STOPS + 1);

  slot_e         kind;
  logic [1:0]    q;
  logic          q_last;
  logic          slot_end;
  logic          sda_s;
  logic          samp;
  logic [7:0]    shreg;
  logic [2:0]    bitn;
  logic [1:0]    bsel;
  logic [1:0]    load_sel;
  logic [7:0]    load_byte;
  logic [TW-1:0] tries;
  logic [IW-1:0] init_left;
  logic          rd_q;
  logic [7:0]    a_q, r_q, w_q;

  i2c_qphase #(.QCYC(QCYC)) u_qphase (
    .clk(clk), .rst(rst), .run(kind != SL_IDLE), .q(q), .q_last(q_last)
  );

  i2c_sync2 #(.INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
  );

  i2c_linectl u_lines (
    .clk(clk), .rst(rst), .kind(kind), .q(q), .tx_bit(shreg[7]),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign slot_end = q_last && (q == 2'd3);
  assign busy     = (kind != SL_IDLE);

  // Byte to shift next: after an acknowledge it is the following one
  always_comb begin
    load_sel = (kind == SL_ACK) ? bsel + 2'd1 : bsel;
    case (load_sel)
      2'd0:    load_byte = a_q;
      2'd1:    load_byte = r_q;
      default: load_byte = rd_q ? {a_q[7:1], 1'b1} : w_q;
    endcase
  end

  // Sample SDA late in quarter 3, with SCL released
  always_ff @(posedge clk) begin
    if (rst) samp <= 1'b1;
    else if (q_last && q == 2'd2) samp <= sda_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind      <= (INIT_STOPS > 0) ? SL_STOP : SL_IDLE;
      init_left <= IW'(INIT_STOPS);
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
      shreg     <= '0;
      bitn      <= '0;
      bsel      <= '0;
      tries     <= '0;
      rd_q      <= 1'b0;
      a_q       <= '0;
      r_q       <= '0;
      w_q       <= '0;
    end else begin
      done <= 1'b0;
      if (kind == SL_IDLE) begin
        if (go) begin
          rd_q <= cmd_read;
          a_q  <= dev_addr;
          r_q  <= reg_idx;
          w_q  <= wr_data;
          err  <= 1'b0;
          bsel <= 2'd0;
          kind <= SL_START;
        end
      end else if (slot_end) begin
        case (kind)
          SL_START: begin
            shreg <= load_byte;
            bitn  <= '0;
            kind  <= SL_TX;
          end
          SL_TX: begin
            shreg <= {shreg[6:0], 1'b0};
            bitn  <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              kind  <= SL_ACK;
              tries <= '0;
            end
          end
          SL_ACK: begin
            if (!samp) begin
              if (bsel == 2'd2) begin
                bitn <= '0;
                kind <= rd_q ? SL_RX : SL_STOP;
              end else if (bsel == 2'd1 && rd_q) begin
                bsel <= 2'd2;
                kind <= SL_START;
              end else begin
                bsel  <= bsel + 2'd1;
                shreg <= load_byte;
                bitn  <= '0;
                kind  <= SL_TX;
              end
            end else if (tries == TW'(ACK_TRIES - 1)) begin
              err  <= 1'b1;
              kind <= SL_STOP;
            end else begin
              tries <= tries + TW'(1);
            end
          end
          SL_RX: begin
            shreg <= {shreg[6:0], samp};
            bitn  <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              rd_data <= {shreg[6:0], samp};
              kind    <= SL_STOP;
            end
          end
          SL_STOP: begin
            if (init_left > IW'(1)) begin
              init_left <= init_left - IW'(1);
            end else if (init_left == IW'(1)) begin
              init_left <= '0;
              kind      <= SL_IDLE;
            end else begin
              kind <= SL_IDLE;
              done <= 1'b1;
            end
          end
          default: kind <= SL_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regxfer_chk.sv
module i2c_regxfer_chk (
  input logic clk,
  input logic rst,
  input logic go,
  input logic busy,
  input logic done,
  input logic err,
  input logic scl_oe,
  input logic sda_oe
);
  // R2: the two lines never move in the same cycle
  a_r2_lines_apart: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> $stable(sda_oe));

  // R3: both lines released whenever the block is idle
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: done only once busy has dropped
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: a frame only begins after a go
  a_r10_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

  // R9: err clears only when a new command is taken
  a_r9_err_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> $rose(busy));
endmodule

bind i2c_regxfer i2c_regxfer_chk u_chk (
  .clk(clk), .rst(rst), .go(go), .busy(busy), .done(done), .err(err),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_regxfer_test.sv
`timescale 1ns/1ps
module i2c_regxfer_test;
  localparam int QC = 4;
  localparam int TRIES = 4;
  localparam int NSTOP = 3;
  localparam int NEVER = 99;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic cmd_read = 1'b0;
  logic [7:0] dev_addr = '0, reg_idx = '0, wr_data = '0;
  logic busy, done, err, scl_oe, sda_oe;
  logic [7:0] rd_data;
  logic s_pull = 1'b0;
  logic scl_bus, sda_bus;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | s_pull);

  always #2 clk = ~clk;

  i2c_regxfer #(.QCYC(QC), .ACK_TRIES(TRIES), .INIT_STOPS(NSTOP)) uut (
    .clk(clk), .rst(rst), .go(go), .cmd_read(cmd_read), .dev_addr(dev_addr),
    .reg_idx(reg_idx), .wr_data(wr_data), .sda_in(sda_bus), .busy(busy),
    .done(done), .err(err), .rd_data(rd_data), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_done = 0, nbytes = 0;
  int lowrun = 0, bad_low = 0, n_low = 0;
  logic [7:0] blog [0:3];
  int ack_delay [0:2];
  logic [7:0] rd_val = '0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slave model and bus monitor, evaluated away from the active edge
  initial begin
    logic ps, pd, cs, cd, ackph, txmode;
    logic [7:0] sh;
    int bitpos, wait_left, fbyte;
    ps = 1'b1; pd = 1'b1; ackph = 1'b0; txmode = 1'b0; sh = '0;
    bitpos = 0; wait_left = 0; fbyte = 0;
    forever begin
      @(negedge clk);
      cs = scl_bus; cd = sda_bus;
      if (done) n_done++;
      if (scl_oe) lowrun++;
      else if (lowrun > 0) begin
        n_low++;
        if (lowrun != 2 * QC) bad_low++;
        lowrun = 0;
      end
      if (ps && cs && pd && !cd) begin
        n_start++; bitpos = 0; ackph = 0; txmode = 0; s_pull = 0; fbyte = 0;
      end else if (ps && cs && !pd && cd) begin
        n_stop++; bitpos = 0; ackph = 0; txmode = 0; s_pull = 0;
      end else if (!ps && cs) begin
        n_rise++;
        if (!ackph && bitpos < 8) begin
          if (!txmode) sh = {sh[6:0], cd};
          bitpos++;
        end
      end else if (ps && !cs) begin
        if (ackph) begin
          if (s_pull) begin
            s_pull = 0; ackph = 0; bitpos = 0;
            if (fbyte == 1 && sh[0]) begin
              txmode = 1; s_pull = ~rd_val[7];
            end
          end else begin
            wait_left--;
            if (wait_left <= 0) s_pull = 1;
          end
        end else if (txmode) begin
          s_pull = (bitpos < 8) ? ~rd_val[7 - bitpos] : 1'b0;
        end else if (bitpos == 8) begin
          ackph = 1;
          if (nbytes < 4) blog[nbytes] = sh;
          wait_left = (nbytes < 3) ? ack_delay[nbytes] : 0;
          nbytes++; fbyte++;
          if (wait_left == 0) s_pull = 1;
        end
      end
      ps = cs; pd = cd;
    end
  end

  task automatic run_cmd(input logic rd, input logic [7:0] a, r, w,
                         input int d0, d1, d2, input logic [7:0] rv);
    int t;
    ack_delay[0] = d0; ack_delay[1] = d1; ack_delay[2] = d2;
    rd_val = rv; nbytes = 0;
    n_start = 0; n_stop = 0; n_rise = 0; n_done = 0;
    @(negedge clk);
    cmd_read = rd; dev_addr = a; reg_idx = r; wr_data = w; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 5000) chk("R10 frame completes", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t, exp_r;
    logic [7:0] dat, last_rd;
    repeat (3) @(negedge clk);
    chk("R3 reset scl released", scl_oe, 0);
    chk("R3 reset sda released", sda_oe, 0);
    chk("R1 busy in reset", busy, 1);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    go = 1'b1; cmd_read = 1'b0;
    @(negedge clk);
    go = 1'b0;
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk("R1 init stops", n_stop, NSTOP);
    chk("R1 no start at init", n_start, 0);
    chk("R1 no done at init", n_done, 0);
    repeat (100) @(negedge clk);
    chk("R1 go ignored during init", n_start, 0);
    chk("R3 idle lines", {30'd0, scl_oe, sda_oe}, 0);

    // R7 R5 R6: write sweep over acknowledge delays and values
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 8; k++) begin
        dat = 8'(k * 37 + d * 5);
        run_cmd(1'b0, 8'h58, 8'(8'h10 + k), dat, d, (d + 1) % 4, (d + 2) % 4, 8'h00);
        chk("R7 addr byte", blog[0], 8'h58);
        chk("R7 reg byte", blog[1], 8'h10 + k);
        chk("R5 data byte", blog[2], dat);
        chk("R7 byte count", nbytes, 3);
        chk("R4 one start", n_start, 1);
        chk("R4 one stop", n_stop, 1);
        exp_r = 29 + d + (d + 1) % 4 + (d + 2) % 4;
        chk("R6 scl pulses", n_rise, exp_r);
        chk("R9 no err", err, 0);
        chk("R10 one done", n_done, 1);
      end
    end

    // R8: read sweep
    for (int i = 0; i < 16; i++) begin
      dat = 8'(i * 17) ^ 8'h5A;
      run_cmd(1'b1, 8'hA0, 8'(i * 3), 8'hFF, i % 4, (i + 3) % 4, (i / 4) % 4, dat);
      chk("R8 read data", rd_data, dat);
      chk("R8 addr byte", blog[0], 8'hA0);
      chk("R8 reg byte", blog[1], 8'(i * 3));
      chk("R8 read addr bit0 set", blog[2], 8'hA1);
      chk("R8 repeated start", n_start, 2);
      chk("R8 one stop", n_stop, 1);
      exp_r = 38 + i % 4 + (i + 3) % 4 + (i / 4) % 4;
      chk("R8 scl pulses", n_rise, exp_r);
      chk("R9 no err on read", err, 0);
    end
    last_rd = rd_data;

    // R9: missing acknowledge at each write byte
    for (int k = 0; k < 3; k++) begin
      run_cmd(1'b0, 8'h58, 8'h22, 8'h33, (k == 0) ? NEVER : 1,
              (k == 1) ? NEVER : 1, (k == 2) ? NEVER : 1, 8'h00);
      chk("R9 err set", err, 1);
      chk("R9 bytes skipped", nbytes, k + 1);
      chk("R9 stop issued", n_stop, 1);
      chk("R9 done once", n_done, 1);
      chk("R6 retry pulses", n_rise, 1 + 10 * k + 8 + TRIES + 1);
    end

    // R9: read address rejected keeps rd_data
    run_cmd(1'b1, 8'hA0, 8'h07, 8'h00, 0, 0, NEVER, 8'hC3);
    chk("R9 read err", err, 1);
    chk("R9 rd_data kept", rd_data, last_rd);
    chk("R9 read stop", n_stop, 1);
    chk("R9 read starts", n_start, 2);

    // R9 R10: next command clears err; go while busy is ignored
    fork
      run_cmd(1'b0, 8'h58, 8'h44, 8'h96, 0, 0, 0, 8'h00);
      begin
        repeat (100) @(negedge clk);
        cmd_read = 1'b1; dev_addr = 8'hA0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
      end
    join
    chk("R9 err cleared", err, 0);
    chk("R10 busy go ignored start", n_start, 1);
    chk("R10 busy go ignored byte", blog[2], 8'h96);
    repeat (300) @(negedge clk);
    chk("R10 no second frame", n_start, 1);
    chk("R10 idle after", busy, 0);

    chk("R2 scl low width", bad_low, 0);
    chk("R2 low pulses seen", (n_low > 100) ? 1 : 0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule